// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a shared address translation buffer used by both instruction and data accesses. It has 64 entries. Each entry holds two 32-bit words. The tag word carries an effective page number, a 3-bit page-size code and a valid flag. The data word carries a real page number, execute and write permissions, a zone field and four cache-attribute bits. The hardware never refills an entry by itself. Software loads and inspects entries through an indexed word port, and it can ask which entry covers a given address with a search command.

A lookup port translates one effective address per cycle. Every valid entry is compared against the address, and only the bits above that entry's page offset take part. The winning entry supplies the upper bits of the physical address, and the offset bits pass through unchanged. The result also gives the permission and attribute bits and a protection-fault flag. Two invalidate commands are provided: one clears every entry that covers a given address, and the other clears the whole buffer.

Top module: `sizedPageTlb`

## Requirements
- R1: After reset every entry reads as all zeros, and any lookup reports a miss.
- R2: With swValid high and swWrite high, swWData is stored into entry swIndex: the tag word when swWordSel is 0, the data word when it is 1. With swWrite low, rdValid pulses one cycle later and rdData holds the selected word.
- R3: The tag word layout is: effective page number in bits 31..10, size code in bits 9..7, valid flag in bit 6. Code c gives a page of 1 KiB times 4^c. A valid entry matches an address when address bits 31..(10+2c) equal the same bits of its tag.
- R4: On a hit, lkPhys bits above 10+2c come from the real page number (data bits 31..10), and lkPhys bits below 10+2c are copied from lkAddr.
- R5: On a hit, lkExec is data bit 9, lkWrite is data bit 8, and lkAttr is data bits 3..0 (write-through, cache-inhibit, coherent, guarded, from bit 3 down to bit 0).
- R6: When several valid entries match, the entry with the lowest index supplies the result.
- R7: When no valid entry matches, lkMiss is 1, and lkPhys, lkExec, lkWrite, lkAttr and lkFault are all 0.
- R8: A search issued in one cycle gives srchDone, srchFound and the lowest matching index in srchIndex one cycle later. When nothing matches, srchFound is 0 and srchIndex is 0.
- R9: invOne clears the valid flag of every entry that matches invAddr. The other entries keep their contents.
- R10: invAll clears the valid flag of every entry. It takes priority over invOne and over a write in the same cycle.
- R11: On a hit, lkFault is 1 when lkIsWrite is set and the write bit is clear, or when lkIsFetch is set and the execute bit is clear. Otherwise it is 0.
- R12: An entry whose valid flag is 0 never matches, whatever its other bits hold.
- R13: The lookup result appears one cycle after lkValid, with lkDone high in that cycle only. A lookup sees the buffer contents from before any write or invalidate issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swValid | input | 1 | Software word access request |
| swWrite | input | 1 | 1 = write, 0 = read |
| swWordSel | input | 1 | 0 = tag word, 1 = data word |
| swIndex | input | 6 | Entry index |
| swWData | input | 32 | Write data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| invOne | input | 1 | Invalidate the entries matching invAddr |
| invAll | input | 1 | Invalidate all entries |
| invAddr | input | 32 | Address for invOne |
| srchValid | input | 1 | Search request |
| srchAddr | input | 32 | Search address |
| srchDone | output | 1 | Search result valid |
| srchFound | output | 1 | A matching entry exists |
| srchIndex | output | 6 | Lowest matching index |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Effective address |
| lkIsWrite | input | 1 | Lookup is a write access |
| lkIsFetch | input | 1 | Lookup is an instruction fetch |
| lkDone | output | 1 | Lookup result valid |
| lkMiss | output | 1 | No valid entry matched |
| lkPhys | output | 32 | Physical address |
| lkExec | output | 1 | Execute permitted |
| lkWrite | output | 1 | Write permitted |
| lkAttr | output | 4 | Cache attributes |
| lkFault | output | 1 | Protection fault |

## Verification
The assertions check on every cycle:
- the one-cycle handshakes of reads, searches and lookups;
- the zeroed result on a miss and on a failed search;
- that the page offset passes through on a hit;
- that a fault appears only when the requested access lacks its permission;
- that a lookup right after a whole-buffer invalidate misses.

Only the directed scenarios can show the rest:
- that each of the eight page sizes compares exactly the right bits;
- that the lowest index wins;
- that a single invalidate spares the entries that do not match;
- that an entry written with its valid flag clear stays invisible.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int WORD_W = 32;
  localparam int BASE_SHIFT = 10;
  localparam int VALID_BIT = 6;
  localparam int EXEC_BIT = 9;
  localparam int WRITE_BIT = 8;
  localparam int ATTR_W = 4;

  typedef struct packed {
    logic wrTag;
    logic wrData;
    logic rdReq;
    logic invMatch;
    logic invEvery;
    logic srchReq;
    logic lkReq;
  } tlbStrobes_t;

  // Mask that keeps only the page-number bits for a given size code
  function automatic logic [WORD_W-1:0] pageMask(input logic [2:0] code);
    int sh;
    sh = BASE_SHIFT + 2 * int'(code);
    return ~((WORD_W'(1) << sh) - WORD_W'(1));
  endfunction

  function automatic logic entryHit(input logic [WORD_W-1:0] tag,
                                    input logic [WORD_W-1:0] addr);
    return tag[VALID_BIT] && (((tag ^ addr) & pageMask(tag[9:7])) == '0);
  endfunction
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic        swValid,
  input  logic        swWrite,
  input  logic        swWordSel,
  input  logic        invOne,
  input  logic        invAll,
  input  logic        srchValid,
  input  logic        lkValid,
  output tlbStrobes_t strobes
);
  logic anyInv;

  always_comb begin
    anyInv = invOne || invAll;
    strobes.invEvery = invAll;
    strobes.invMatch = invOne && !invAll;
    strobes.wrTag = swValid && swWrite && !swWordSel && !anyInv;
    strobes.wrData = swValid && swWrite && swWordSel && !anyInv;
    strobes.rdReq = swValid && !swWrite;
    strobes.srchReq = srchValid;
    strobes.lkReq = lkValid;
  end
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strobes,
  input  logic               swWordSel,
  input  logic [IDX_W-1:0]   swIndex,
  input  logic [WORD_W-1:0]  swWData,
  input  logic [WORD_W-1:0]  invAddr,
  input  logic [WORD_W-1:0]  srchAddr,
  input  logic [WORD_W-1:0]  lkAddr,
  input  logic               lkIsWrite,
  input  logic               lkIsFetch,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  output logic               srchDone,
  output logic               srchFound,
  output logic [IDX_W-1:0]   srchIndex,
  output logic               lkDone,
  output logic               lkMiss,
  output logic [WORD_W-1:0]  lkPhys,
  output logic               lkExec,
  output logic               lkWrite,
  output logic [ATTR_W-1:0]  lkAttr,
  output logic               lkFault
);
  logic [WORD_W-1:0] tagMem [ENTRIES];
  logic [WORD_W-1:0] dataMem [ENTRIES];
  logic [ENTRIES-1:0] lkHit, srchHit, invHit;

  for (genvar i = 0; i < ENTRIES; i++) begin : gMatch
    assign lkHit[i] = entryHit(tagMem[i], lkAddr);
    assign srchHit[i] = entryHit(tagMem[i], srchAddr);
    assign invHit[i] = entryHit(tagMem[i], invAddr);
  end

  logic lkAny, srchAny;
  logic [IDX_W-1:0] lkIdx, srchIdx;

  always_comb begin
    lkAny = 1'b0;
    lkIdx = '0;
    srchAny = 1'b0;
    srchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkHit[i]) begin
        lkAny = 1'b1;
        lkIdx = IDX_W'(i);
      end
      if (srchHit[i]) begin
        srchAny = 1'b1;
        srchIdx = IDX_W'(i);
      end
    end
  end

  logic [WORD_W-1:0] winTag, winData, winMask;
  always_comb begin
    winTag = tagMem[lkIdx];
    winData = dataMem[lkIdx];
    winMask = pageMask(winTag[9:7]);
  end

  // Entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i] <= '0;
        dataMem[i] <= '0;
      end
    end else begin
      if (strobes.wrTag) tagMem[swIndex] <= swWData;
      if (strobes.wrData) dataMem[swIndex] <= swWData;
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.invEvery || (strobes.invMatch && invHit[i]))
          tagMem[i][VALID_BIT] <= 1'b0;
      end
    end
  end

  // Registered results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData <= '0;
      srchDone <= 1'b0;
      srchFound <= 1'b0;
      srchIndex <= '0;
      lkDone <= 1'b0;
      lkMiss <= 1'b0;
      lkPhys <= '0;
      lkExec <= 1'b0;
      lkWrite <= 1'b0;
      lkAttr <= '0;
      lkFault <= 1'b0;
    end else begin
      rdValid <= strobes.rdReq;
      if (strobes.rdReq)
        rdData <= swWordSel ? dataMem[swIndex] : tagMem[swIndex];
      srchDone <= strobes.srchReq;
      srchFound <= strobes.srchReq && srchAny;
      srchIndex <= (strobes.srchReq && srchAny) ? srchIdx : '0;
      lkDone <= strobes.lkReq;
      if (strobes.lkReq && lkAny) begin
        lkMiss <= 1'b0;
        lkPhys <= (winData & winMask) | (lkAddr & ~winMask);
        lkExec <= winData[EXEC_BIT];
        lkWrite <= winData[WRITE_BIT];
        lkAttr <= winData[ATTR_W-1:0];
        lkFault <= (lkIsWrite && !winData[WRITE_BIT]) ||
                   (lkIsFetch && !winData[EXEC_BIT]);
      end else begin
        lkMiss <= strobes.lkReq;
        lkPhys <= '0;
        lkExec <= 1'b0;
        lkWrite <= 1'b0;
        lkAttr <= '0;
        lkFault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sizedPageTlb.sv
module sizedPageTlb
  import tlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swValid,
  input  logic               swWrite,
  input  logic               swWordSel,
  input  logic [IDX_W-1:0]   swIndex,
  input  logic [WORD_W-1:0]  swWData,
  output logic               rdValid,
  output logic [WORD_W-1:0]  rdData,
  input  logic               invOne,
  input  logic               invAll,
  input  logic [WORD_W-1:0]  invAddr,
  input  logic               srchValid,
  input  logic [WORD_W-1:0]  srchAddr,
  output logic               srchDone,
  output logic               srchFound,
  output logic [IDX_W-1:0]   srchIndex,
  input  logic               lkValid,
  input  logic [WORD_W-1:0]  lkAddr,
  input  logic               lkIsWrite,
  input  logic               lkIsFetch,
  output logic               lkDone,
  output logic               lkMiss,
  output logic [WORD_W-1:0]  lkPhys,
  output logic               lkExec,
  output logic               lkWrite,
  output logic [ATTR_W-1:0]  lkAttr,
  output logic               lkFault
);
  tlbStrobes_t strobes;

  tlbCtrl ctrl (
    .swValid(swValid), .swWrite(swWrite), .swWordSel(swWordSel),
    .invOne(invOne), .invAll(invAll), .srchValid(srchValid),
    .lkValid(lkValid), .strobes(strobes)
  );

  tlbDatapath #(.ENTRIES(ENTRIES)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .swWordSel(swWordSel),
    .swIndex(swIndex), .swWData(swWData), .invAddr(invAddr),
    .srchAddr(srchAddr), .lkAddr(lkAddr), .lkIsWrite(lkIsWrite),
    .lkIsFetch(lkIsFetch), .rdValid(rdValid), .rdData(rdData),
    .srchDone(srchDone), .srchFound(srchFound), .srchIndex(srchIndex),
    .lkDone(lkDone), .lkMiss(lkMiss), .lkPhys(lkPhys), .lkExec(lkExec),
    .lkWrite(lkWrite), .lkAttr(lkAttr), .lkFault(lkFault)
  );
endmodule

// File: rtl/tlbChecker.sv
module tlbChecker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             swValid,
  input logic             swWrite,
  input logic             rdValid,
  input logic             invAll,
  input logic             srchValid,
  input logic             srchDone,
  input logic             srchFound,
  input logic [IDX_W-1:0] srchIndex,
  input logic             lkValid,
  input logic [31:0]      lkAddr,
  input logic             lkIsWrite,
  input logic             lkIsFetch,
  input logic             lkDone,
  input logic             lkMiss,
  input logic [31:0]      lkPhys,
  input logic             lkExec,
  input logic             lkWrite,
  input logic [3:0]       lkAttr,
  input logic             lkFault
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (swValid && !swWrite) |=> rdValid);

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !invAll) |=> (lkDone && (lkMiss || lkPhys[9:0] == $past(lkAddr[9:0]))));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkDone && lkMiss) |-> (lkPhys == '0 && !lkExec && !lkWrite && lkAttr == '0 && !lkFault));

  assert_search_timing_R8: assert property (@(posedge clk) disable iff (!rstN)
    srchValid |=> srchDone);

  assert_search_none_R8: assert property (@(posedge clk) disable iff (!rstN)
    (srchDone && !srchFound) |-> (srchIndex == '0));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && !lkValid) |=> (lkValid |=> lkMiss));

  assert_fault_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (lkFault == (!lkMiss &&
      (($past(lkIsWrite) && !lkWrite) || ($past(lkIsFetch) && !lkExec)))));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkDone);
endmodule

bind sizedPageTlb tlbChecker #(.IDX_W(IDX_W)) chk (
  .clk(clk), .rstN(rstN), .swValid(swValid), .swWrite(swWrite),
  .rdValid(rdValid), .invAll(invAll), .srchValid(srchValid),
  .srchDone(srchDone), .srchFound(srchFound), .srchIndex(srchIndex),
  .lkValid(lkValid), .lkAddr(lkAddr), .lkIsWrite(lkIsWrite),
  .lkIsFetch(lkIsFetch), .lkDone(lkDone), .lkMiss(lkMiss),
  .lkPhys(lkPhys), .lkExec(lkExec), .lkWrite(lkWrite),
  .lkAttr(lkAttr), .lkFault(lkFault)
);

// File: tb/sizedPageTlb_test.sv
module sizedPageTlb_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swValid = 0, swWrite = 0, swWordSel = 0;
  logic [5:0] swIndex = '0;
  logic [31:0] swWData = '0;
  logic rdValid;
  logic [31:0] rdData;
  logic invOne = 0, invAll = 0;
  logic [31:0] invAddr = '0;
  logic srchValid = 0;
  logic [31:0] srchAddr = '0;
  logic srchDone, srchFound;
  logic [5:0] srchIndex;
  logic lkValid = 0, lkIsWrite = 0, lkIsFetch = 0;
  logic [31:0] lkAddr = '0;
  logic lkDone, lkMiss, lkExec, lkWrite, lkFault;
  logic [31:0] lkPhys;
  logic [3:0] lkAttr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sizedPageTlb uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkTag(input logic [31:0] va, input int code, input bit v);
    return (va & 32'hFFFF_FC00) | (32'(code) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mkData(input logic [31:0] pa, input bit ex, input bit wr,
                                         input logic [3:0] attr);
    return (pa & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | 32'h50 | 32'(attr);
  endfunction

  task automatic writeWord(input int idx, input bit sel, input logic [31:0] d);
    @(negedge clk);
    swValid = 1; swWrite = 1; swWordSel = sel; swIndex = 6'(idx); swWData = d;
    @(negedge clk);
    swValid = 0; swWrite = 0;
  endtask

  task automatic readWord(input string req, input int idx, input bit sel, input logic [31:0] exp);
    @(negedge clk);
    swValid = 1; swWrite = 0; swWordSel = sel; swIndex = 6'(idx);
    @(negedge clk);
    swValid = 0;
    check(req, {rdValid, rdData}, {1'b1, exp});
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input bit w, input bit f,
                        input bit expMiss, input logic [31:0] expPhys, input bit expEx,
                        input bit expWr, input logic [3:0] expAttr, input bit expFault);
    @(negedge clk);
    lkValid = 1; lkAddr = a; lkIsWrite = w; lkIsFetch = f;
    @(negedge clk);
    lkValid = 0; lkIsWrite = 0; lkIsFetch = 0;
    check(req, {lkDone, lkMiss, lkPhys, lkExec, lkWrite, lkAttr, lkFault},
          {1'b1, expMiss, expPhys, expEx, expWr, expAttr, expFault});
  endtask

  task automatic search(input string req, input logic [31:0] a, input bit expFound,
                        input int expIdx);
    @(negedge clk);
    srchValid = 1; srchAddr = a;
    @(negedge clk);
    srchValid = 0;
    check(req, {srchDone, srchFound, srchIndex}, {1'b1, expFound, 6'(expIdx)});
  endtask

  task automatic testReset();
    readWord("R1 tag after reset", 5, 0, 32'h0);
    readWord("R1 data after reset", 63, 1, 32'h0);
    lookup("R1 lookup after reset", 32'h1234_5678, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic testReadBack();
    writeWord(7, 0, 32'hABCD_E4FF);
    writeWord(7, 1, 32'h1357_9BDF);
    readWord("R2 tag word", 7, 0, 32'hABCD_E4FF);
    readWord("R2 data word", 7, 1, 32'h1357_9BDF);
    writeWord(7, 0, 32'h0);
  endtask

  task automatic testSizes();
    for (int c = 0; c < 8; c++) begin
      int sh;
      logic [31:0] lowMask, va, pa, exp;
      sh = 10 + 2 * c;
      lowMask = (32'd1 << sh) - 1;
      pa = 32'h8ABC_DC00;
      writeWord(0, 1, mkData(pa, 1, 1, 4'h0));
      writeWord(0, 0, mkTag(32'h4000_0000, c, 1));
      va = 32'h4000_0000 | (32'h00FF_FFFF & lowMask);
      exp = (pa & ~lowMask) | (va & lowMask);
      lookup($sformatf("R3 R4 hit size code %0d", c), va, 0, 0, 0, exp, 1, 1, 4'h0, 0);
      lookup($sformatf("R3 miss above page size code %0d", c),
             32'h4000_0000 | (32'd1 << sh), 0, 0, 1, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic testPriorityAndSearch();
    writeWord(20, 1, mkData(32'hBBBB_0000, 1, 1, 4'h3));
    writeWord(20, 0, mkTag(32'h1230_0000, 1, 1));
    writeWord(10, 1, mkData(32'hAAAA_0000, 1, 1, 4'hA));
    writeWord(10, 0, mkTag(32'h1230_0000, 1, 1));
    lookup("R6 R5 lowest index wins", 32'h1230_0123, 0, 0, 0, 32'hAAAA_0123, 1, 1, 4'hA, 0);
    search("R8 search finds lowest", 32'h1230_0FFF, 1, 10);
    search("R8 search none", 32'h5555_0000, 0, 0);
  endtask

  task automatic testFaults();
    writeWord(30, 1, mkData(32'hC000_0000, 0, 1, 4'h5));
    writeWord(30, 0, mkTag(32'h2000_0000, 0, 1));
    lookup("R11 fetch without exec", 32'h2000_0004, 0, 1, 0, 32'hC000_0004, 0, 1, 4'h5, 1);
    lookup("R11 write allowed", 32'h2000_0008, 1, 0, 0, 32'hC000_0008, 0, 1, 4'h5, 0);
    writeWord(31, 1, mkData(32'hD000_0000, 1, 0, 4'h1));
    writeWord(31, 0, mkTag(32'h2100_0000, 0, 1));
    lookup("R11 write without permission", 32'h2100_0010, 1, 0, 0, 32'hD000_0010, 1, 0, 4'h1, 1);
    lookup("R11 fetch allowed", 32'h2100_0010, 0, 1, 0, 32'hD000_0010, 1, 0, 4'h1, 0);
  endtask

  task automatic testInvalidFlag();
    writeWord(40, 1, mkData(32'hE000_0000, 1, 1, 4'h0));
    writeWord(40, 0, mkTag(32'h7000_0000, 0, 0));
    lookup("R12 invalid entry ignored", 32'h7000_0000, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic testInvalidateOne();
    @(negedge clk);
    invOne = 1; invAddr = 32'h1230_0000;
    @(negedge clk);
    invOne = 0;
    search("R9 matching entries cleared", 32'h1230_0000, 0, 0);
    readWord("R9 valid flag cleared", 10, 0, mkTag(32'h1230_0000, 1, 0));
    search("R9 other entry kept", 32'h2000_0000, 1, 30);
  endtask

  task automatic testInvalidateAllAndSameCycle();
    // R13: a lookup in the same cycle as a write sees the old contents.
    @(negedge clk);
    swValid = 1; swWrite = 1; swWordSel = 0; swIndex = 6'd50;
    swWData = mkTag(32'h3000_0000, 0, 1);
    lkValid = 1; lkAddr = 32'h3000_0000;
    @(negedge clk);
    swValid = 0; swWrite = 0; lkValid = 0;
    check("R13 same-cycle write not seen", {lkDone, lkMiss}, 2'b11);
    @(negedge clk);
    check("R13 done is a single pulse", lkDone, 0);
    // R10: invAll wins over a write issued in the same cycle.
    @(negedge clk);
    invAll = 1;
    swValid = 1; swWrite = 1; swWordSel = 0; swIndex = 6'd51;
    swWData = mkTag(32'h3100_0000, 0, 1);
    @(negedge clk);
    invAll = 0; swValid = 0; swWrite = 0;
    lookup("R10 all cleared", 32'h2000_0000, 0, 0, 1, 0, 0, 0, 0, 0);
    search("R10 entry 50 cleared", 32'h3000_0000, 0, 0);
    readWord("R10 write dropped under invAll", 51, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testReadBack();
    testSizes();
    testPriorityAndSearch();
    testFaults();
    testInvalidFlag();
    testInvalidateOne();
    testInvalidateAllAndSameCycle();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule